// File: doc/BRIEF.md
# Processor Trap Classifier and Retry Arbiter

This block sits beside a small processor sequencer and watches what the sequencer reports each cycle. It follows the processor through the three phases of a trap or interrupt entry: the entry is started, the instruction at the vector location is fetched, and that instruction is executed. It uses this phase to sort fault reports into trap vectors. An instruction exception goes out on vector 0x4D with a three-bit condition code naming the fault. A hardware error is either granted an automatic retry or sent to vector 0x4C. Power-loss and power-restore events become traps on 0x51 and 0x50.

The block also keeps a sticky processor-fault flag, which software clears with a strobe. Every trap is raised as a one-cycle request. The vector and code stay on the outputs until the processor acknowledges the trap, and only one trap is outstanding at a time. The block does not execute instructions, exchange status words or touch memory.

Top module: `trap_classifier`

## Requirements
- R1: After synchronous active-high reset, `trap_req`, `trap_vec`, `trap_tcc`, `retry_grant`, `pdf_flag` and `in_entry` are all zero.
- R2: A cycle with `entry_start` makes `in_entry` high from the next cycle. The sequence spends one cycle in the initiate phase and one in the fetch phase, then stays in the execute phase until a cycle with `exec_done`. `in_entry` falls in the cycle after that.
- R3: In the execute phase, `exec_valid` with an opcode class that is not legal for the entry kind raises trap 0x4D with code 110. For a trap entry (`entry_is_intr`=0) the legal classes are 1 (exchange status) and 2 (push status). An interrupt entry also allows 3, 4 and 5 (modify-and-test byte, halfword and word).
- R4: `exec_valid` with opcode class 9 (memory control) raises 0x4D with code 001 unless `mem_cfg` is 3'b100, 3'b010, 3'b101, 3'b001 or 3'b011.
- R5: `exec_valid` with a bad register raises 0x4D with code 000 and leaves `pdf_flag` unchanged. A bad register is an odd `reg_num` with class 6 (doubleword add or subtract), or `reg_num`=0 with class 7 (long floating), 8 (byte string) or 9 (memory control).
- R6: `proc_fault` while `in_entry` is high raises 0x4D with code 111. Outside a sequence it raises no trap.
- R7: When several exception conditions hold in the same cycle, one trap is raised. The code is chosen in this order: 111, then 110, then 001, then 000.
- R8: `pdf_flag` is set one cycle after `proc_fault` or after any exception with code 110 or 001. It clears one cycle after `pdf_clr` only when no set cause is present in that cycle.
- R9: `retry_grant` pulses one cycle after `hw_err` only when `in_entry`, `reg_altered` and `retry_inhibit` are all zero.
- R10: A `hw_err` that is not retried raises trap 0x4C with code 000. It is held pending until it can be issued.
- R11: A rising `pwr_down` raises trap 0x51. The trap is held pending and is issued only in a cycle with `interruptible` high.
- R12: When `pwr_down` falls after being high for fewer than `OUTAGE_LIMIT` clock edges, trap 0x50 is raised. A longer outage raises no 0x50 trap.
- R13: `trap_req` is a one-cycle pulse, and `trap_vec` and `trap_tcc` hold their values until `trap_ack`. No new trap is issued while one is unacknowledged, except in the cycle of `trap_ack` itself. Instruction exceptions that arrive while a trap is unacknowledged are dropped. Sources are served in this order: exception, hardware error, power-off, power-on. `trap_tcc` is zero for every vector other than 0x4D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_start | input | 1 | Trap or interrupt entry begins |
| entry_is_intr | input | 1 | Entry is an interrupt (1) or a trap (0) |
| exec_done | input | 1 | Vector-location instruction finished |
| exec_valid | input | 1 | Instruction decode fields are valid |
| op_class | input | 4 | Decoded opcode class |
| mem_cfg | input | 3 | Memory-control configuration field |
| reg_num | input | 4 | Designated register number |
| proc_fault | input | 1 | Processor-detected fault strobe |
| hw_err | input | 1 | Hardware error strobe |
| reg_altered | input | 1 | Register-altered status |
| retry_inhibit | input | 1 | Retry-inhibit control bit |
| pwr_down | input | 1 | Supply power is absent |
| interruptible | input | 1 | Processor is at an interruptible point |
| pdf_clr | input | 1 | Software clear of the fault flag |
| trap_ack | input | 1 | Processor accepted the trap |
| trap_req | output | 1 | One-cycle trap request |
| trap_vec | output | 8 | Trap vector address |
| trap_tcc | output | 3 | Trap condition code |
| retry_grant | output | 1 | Automatic retry granted |
| pdf_flag | output | 1 | Sticky processor-detected-fault flag |
| in_entry | output | 1 | Entry sequence in progress |

## Verification
Two pairs of events can meet in one cycle. The first is an instruction exception and an un-retried hardware error. The second is a power-off event and a power-on event that arrive while a trap is still unacknowledged. The bench provokes both by holding back the acknowledge, then injecting a fresh exception, a hardware error and a power change before releasing it. It then judges which vector wins each free slot and that the dropped exception never comes back. A cycle-by-cycle behavioural model predicts every output on every clock, so an arbitration slip shows up in the exact cycle it happens.

// File: rtl/trapcls_pkg.sv
package trapcls_pkg;
    localparam int VEC_W = 8;
    localparam int TCC_W = 3;
    localparam int OPC_W = 4;
    localparam int REG_W = 4;
    localparam int CFG_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_OTHER    = 4'd0,
        OPC_SWAP_PSD = 4'd1,
        OPC_PUSH_ST  = 4'd2,
        OPC_MOD_BYTE = 4'd3,
        OPC_MOD_HALF = 4'd4,
        OPC_MOD_WORD = 4'd5,
        OPC_DW_ARITH = 4'd6,
        OPC_LONG_FP  = 4'd7,
        OPC_BYTE_STR = 4'd8,
        OPC_MEM_CTL  = 4'd9
    } opc_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_INIT  = 2'd1,
        PH_FETCH = 2'd2,
        PH_EXEC  = 2'd3
    } phase_e;

    localparam logic [VEC_W-1:0] VEC_HWERR   = 8'h4C;
    localparam logic [VEC_W-1:0] VEC_IEXC    = 8'h4D;
    localparam logic [VEC_W-1:0] VEC_PWR_ON  = 8'h50;
    localparam logic [VEC_W-1:0] VEC_PWR_OFF = 8'h51;

    localparam logic [TCC_W-1:0] TCC_ENTRY_FAULT = 3'b111;
    localparam logic [TCC_W-1:0] TCC_BAD_VEC_OP  = 3'b110;
    localparam logic [TCC_W-1:0] TCC_BAD_MEMCFG  = 3'b001;
    localparam logic [TCC_W-1:0] TCC_BAD_REG     = 3'b000;

    typedef struct packed {
        logic             valid;
        logic [TCC_W-1:0] tcc;
    } exc_t;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
        logic [TCC_W-1:0] tcc;
    } trap_t;

    function automatic logic vector_op_legal(opc_e op, logic is_intr);
        case (op)
            OPC_SWAP_PSD, OPC_PUSH_ST:               return 1'b1;
            OPC_MOD_BYTE, OPC_MOD_HALF, OPC_MOD_WORD: return is_intr;
            default:                                  return 1'b0;
        endcase
    endfunction

    function automatic logic memcfg_legal(logic [CFG_W-1:0] cfg);
        return (cfg == 3'b100) || (cfg == 3'b010) || (cfg == 3'b101) ||
               (cfg == 3'b001) || (cfg == 3'b011);
    endfunction
endpackage

// File: rtl/trapcls_seq.sv
module trapcls_seq
    import trapcls_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   entry_start,
    input  logic   entry_is_intr,
    input  logic   exec_done,
    output phase_e phase,
    output logic   is_intr
);
    phase_e phase_q;
    logic   intr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            intr_q  <= 1'b0;
        end else if (entry_start) begin
            phase_q <= PH_INIT;
            intr_q  <= entry_is_intr;
        end else begin
            case (phase_q)
                PH_INIT:  phase_q <= PH_FETCH;
                PH_FETCH: phase_q <= PH_EXEC;
                PH_EXEC:  if (exec_done) phase_q <= PH_IDLE;
                default:  phase_q <= phase_q;
            endcase
        end
    end

    assign phase   = phase_q;
    assign is_intr = intr_q;
endmodule

// File: rtl/trapcls_decode.sv
module trapcls_decode
    import trapcls_pkg::*;
(
    input  phase_e           phase,
    input  logic             is_intr,
    input  logic             exec_valid,
    input  logic [OPC_W-1:0] op_class,
    input  logic [CFG_W-1:0] mem_cfg,
    input  logic [REG_W-1:0] reg_num,
    input  logic             proc_fault,
    output exc_t             exc,
    output logic             pdf_set
);
    opc_e op;
    logic entry_fault, bad_vec_op, bad_cfg, bad_reg;

    always_comb begin
        op          = opc_e'(op_class);
        entry_fault = proc_fault && (phase != PH_IDLE);
        bad_vec_op  = exec_valid && (phase == PH_EXEC) && !vector_op_legal(op, is_intr);
        bad_cfg     = exec_valid && (op == OPC_MEM_CTL) && !memcfg_legal(mem_cfg);
        bad_reg     = exec_valid &&
                      (((op == OPC_DW_ARITH) && reg_num[0]) ||
                       (((op == OPC_LONG_FP) || (op == OPC_BYTE_STR) ||
                         (op == OPC_MEM_CTL)) && (reg_num == '0)));

        exc.valid = entry_fault | bad_vec_op | bad_cfg | bad_reg;
        if (entry_fault)     exc.tcc = TCC_ENTRY_FAULT;
        else if (bad_vec_op) exc.tcc = TCC_BAD_VEC_OP;
        else if (bad_cfg)    exc.tcc = TCC_BAD_MEMCFG;
        else                 exc.tcc = TCC_BAD_REG;

        pdf_set = proc_fault | bad_vec_op | bad_cfg;
    end
endmodule

// File: rtl/trapcls_power.sv
module trapcls_power #(
    parameter int OUTAGE_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_down,
    input  logic pon_take,
    input  logic poff_take,
    output logic pon_req,
    output logic poff_req
);
    localparam int CNT_W = $clog2(OUTAGE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(OUTAGE_LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic down_q, pon_pend_q, poff_pend_q;
    logic rise, fall;

    assign rise     = pwr_down & ~down_q;
    assign fall     = ~pwr_down & down_q;
    assign pon_req  = pon_pend_q | (fall && (cnt_q < LIMIT_C));
    assign poff_req = poff_pend_q | rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            down_q      <= 1'b0;
            pon_pend_q  <= 1'b0;
            poff_pend_q <= 1'b0;
        end else begin
            down_q      <= pwr_down;
            pon_pend_q  <= pon_req & ~pon_take;
            poff_pend_q <= poff_req & ~poff_take;
            if (!pwr_down)             cnt_q <= '0;
            else if (cnt_q != LIMIT_C) cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/trapcls_issue.sv
module trapcls_issue
    import trapcls_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  exc_t             exc,
    input  logic             err_req,
    input  logic             poff_req,
    input  logic             pon_req,
    input  logic             trap_ack,
    output logic             take_err,
    output logic             take_poff,
    output logic             take_pon,
    output logic             free,
    output logic             trap_req,
    output logic [VEC_W-1:0] trap_vec,
    output logic [TCC_W-1:0] trap_tcc
);
    logic  busy_q, req_q;
    trap_t nxt, held_q;

    assign free = !busy_q || trap_ack;

    always_comb begin
        nxt       = '0;
        take_err  = 1'b0;
        take_poff = 1'b0;
        take_pon  = 1'b0;
        if (free) begin
            if (exc.valid) begin
                nxt = '{valid: 1'b1, vec: VEC_IEXC, tcc: exc.tcc};
            end else if (err_req) begin
                nxt      = '{valid: 1'b1, vec: VEC_HWERR, tcc: '0};
                take_err = 1'b1;
            end else if (poff_req) begin
                nxt       = '{valid: 1'b1, vec: VEC_PWR_OFF, tcc: '0};
                take_poff = 1'b1;
            end else if (pon_req) begin
                nxt      = '{valid: 1'b1, vec: VEC_PWR_ON, tcc: '0};
                take_pon = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            req_q  <= 1'b0;
            held_q <= '0;
        end else begin
            req_q <= nxt.valid;
            if (nxt.valid) begin
                busy_q <= 1'b1;
                held_q <= nxt;
            end else if (trap_ack) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign trap_req = req_q;
    assign trap_vec = held_q.vec;
    assign trap_tcc = held_q.tcc;
endmodule

// File: rtl/trap_classifier.sv
module trap_classifier
    import trapcls_pkg::*;
#(
    parameter int OUTAGE_LIMIT = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             entry_start,
    input  logic             entry_is_intr,
    input  logic             exec_done,
    input  logic             exec_valid,
    input  logic [OPC_W-1:0] op_class,
    input  logic [CFG_W-1:0] mem_cfg,
    input  logic [REG_W-1:0] reg_num,
    input  logic             proc_fault,
    input  logic             hw_err,
    input  logic             reg_altered,
    input  logic             retry_inhibit,
    input  logic             pwr_down,
    input  logic             interruptible,
    input  logic             pdf_clr,
    input  logic             trap_ack,
    output logic             trap_req,
    output logic [VEC_W-1:0] trap_vec,
    output logic [TCC_W-1:0] trap_tcc,
    output logic             retry_grant,
    output logic             pdf_flag,
    output logic             in_entry
);
    phase_e phase;
    logic   is_intr;
    exc_t   exc;
    logic   pdf_set;
    logic   pon_req, poff_req, take_err, take_poff, take_pon, issue_free;
    logic   retry_ok, err_req, err_pend_q, retry_q, pdf_q;
    logic   exc_hit;

    trapcls_seq u_seq (
        .clk(clk), .rst(rst), .entry_start(entry_start),
        .entry_is_intr(entry_is_intr), .exec_done(exec_done),
        .phase(phase), .is_intr(is_intr)
    );

    trapcls_decode u_dec (
        .phase(phase), .is_intr(is_intr), .exec_valid(exec_valid),
        .op_class(op_class), .mem_cfg(mem_cfg), .reg_num(reg_num),
        .proc_fault(proc_fault), .exc(exc), .pdf_set(pdf_set)
    );

    trapcls_power #(.OUTAGE_LIMIT(OUTAGE_LIMIT)) u_pwr (
        .clk(clk), .rst(rst), .pwr_down(pwr_down),
        .pon_take(take_pon), .poff_take(take_poff),
        .pon_req(pon_req), .poff_req(poff_req)
    );

    trapcls_issue u_iss (
        .clk(clk), .rst(rst), .exc(exc), .err_req(err_req),
        .poff_req(poff_req & interruptible), .pon_req(pon_req),
        .trap_ack(trap_ack), .take_err(take_err), .take_poff(take_poff),
        .take_pon(take_pon), .free(issue_free), .trap_req(trap_req),
        .trap_vec(trap_vec), .trap_tcc(trap_tcc)
    );

    assign in_entry = (phase != PH_IDLE);
    assign retry_ok = !in_entry && !reg_altered && !retry_inhibit;
    assign err_req  = err_pend_q | (hw_err & ~retry_ok);
    assign exc_hit  = exc.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            retry_q    <= 1'b0;
            err_pend_q <= 1'b0;
            pdf_q      <= 1'b0;
        end else begin
            retry_q    <= hw_err & retry_ok;
            err_pend_q <= err_req & ~take_err;
            if (pdf_set)      pdf_q <= 1'b1;
            else if (pdf_clr) pdf_q <= 1'b0;
        end
    end

    assign retry_grant = retry_q;
    assign pdf_flag    = pdf_q;
endmodule

// File: rtl/trap_classifier_chk.sv
module trap_classifier_chk (
    input logic       clk,
    input logic       rst,
    input logic       trap_req,
    input logic       trap_ack,
    input logic [7:0] trap_vec,
    input logic [2:0] trap_tcc,
    input logic       retry_grant,
    input logic       hw_err,
    input logic       reg_altered,
    input logic       retry_inhibit,
    input logic       in_entry,
    input logic       pdf_flag,
    input logic       pdf_clr,
    input logic       entry_start,
    input logic       exc_hit,
    input logic       issue_free
);
    a_r13_single_pulse: assert property (@(posedge clk) disable iff (rst)
        trap_req && !trap_ack |=> !trap_req);

    a_r13_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        trap_req && !trap_ack |=> $stable(trap_vec) && $stable(trap_tcc));

    a_r13_code_only_iexc: assert property (@(posedge clk) disable iff (rst)
        trap_req && trap_vec != 8'h4D |-> trap_tcc == 3'b000);

    a_r9_retry_cause: assert property (@(posedge clk) disable iff (rst)
        retry_grant |-> $past(hw_err) && !$past(reg_altered) &&
                        !$past(retry_inhibit) && !$past(in_entry));

    a_r8_clear_only_by_sw: assert property (@(posedge clk) disable iff (rst)
        $fell(pdf_flag) |-> $past(pdf_clr));

    a_r2_entry_tracked: assert property (@(posedge clk) disable iff (rst)
        entry_start |=> in_entry);

    a_r7_exception_wins: assert property (@(posedge clk) disable iff (rst)
        exc_hit && issue_free |=> trap_req && trap_vec == 8'h4D);
endmodule

bind trap_classifier trap_classifier_chk u_chk (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_ack(trap_ack),
    .trap_vec(trap_vec), .trap_tcc(trap_tcc), .retry_grant(retry_grant),
    .hw_err(hw_err), .reg_altered(reg_altered), .retry_inhibit(retry_inhibit),
    .in_entry(in_entry), .pdf_flag(pdf_flag), .pdf_clr(pdf_clr),
    .entry_start(entry_start), .exc_hit(exc_hit), .issue_free(issue_free)
);

// File: tb/trap_classifier_tb_top.sv
`timescale 1ns/1ps
module trap_classifier_tb_top;
    localparam int LIM = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic entry_start = 0, entry_is_intr = 0, exec_done = 0, exec_valid = 0;
    logic [3:0] op_class = 0;
    logic [2:0] mem_cfg = 3'b100;
    logic [3:0] reg_num = 4'd3;
    logic proc_fault = 0, hw_err = 0, reg_altered = 0, retry_inhibit = 0;
    logic pwr_down = 0, interruptible = 1, pdf_clr = 0, trap_ack = 0;
    logic trap_req, retry_grant, pdf_flag, in_entry;
    logic [7:0] trap_vec;
    logic [2:0] trap_tcc;

    always #2 clk = ~clk;

    trap_classifier #(.OUTAGE_LIMIT(LIM)) dut_i (
        .clk(clk), .rst(rst), .entry_start(entry_start), .entry_is_intr(entry_is_intr),
        .exec_done(exec_done), .exec_valid(exec_valid), .op_class(op_class),
        .mem_cfg(mem_cfg), .reg_num(reg_num), .proc_fault(proc_fault),
        .hw_err(hw_err), .reg_altered(reg_altered), .retry_inhibit(retry_inhibit),
        .pwr_down(pwr_down), .interruptible(interruptible), .pdf_clr(pdf_clr),
        .trap_ack(trap_ack), .trap_req(trap_req), .trap_vec(trap_vec),
        .trap_tcc(trap_tcc), .retry_grant(retry_grant), .pdf_flag(pdf_flag),
        .in_entry(in_entry)
    );

    int    n_checks = 0, n_fail = 0;
    string cur_req = "R1";
    bit    auto_ack = 1, running = 0, done = 0;

    // behavioural reference state
    int m_phase, m_cnt;
    bit m_intr, m_busy, m_req, m_retry, m_pdf, m_err_p, m_poff_p, m_pon_p, m_prev;
    int m_vec, m_tcc;
    int nv, nt;
    bit ine, legal, c1, c2, c3, c4, ok, errc, ponc, poffc, free_s, iss, te, to, tp;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_intr = 0; m_busy = 0; m_req = 0; m_retry = 0;
            m_pdf = 0; m_err_p = 0; m_poff_p = 0; m_pon_p = 0; m_prev = 0;
            m_vec = 0; m_tcc = 0;
        end else begin
            ine   = (m_phase != 0);
            legal = (op_class == 1 || op_class == 2) ||
                    (m_intr && op_class >= 3 && op_class <= 5);
            c1 = proc_fault && ine;
            c2 = exec_valid && m_phase == 3 && !legal;
            c3 = exec_valid && op_class == 9 && !(mem_cfg inside {3'b100, 3'b010, 3'b101, 3'b001, 3'b011});
            c4 = exec_valid && ((op_class == 6 && reg_num[0]) ||
                 ((op_class == 7 || op_class == 8 || op_class == 9) && reg_num == 0));
            nt = c1 ? 7 : c2 ? 6 : c3 ? 1 : 0;
            ok    = !ine && !reg_altered && !retry_inhibit;
            errc  = m_err_p || (hw_err && !ok);
            ponc  = m_pon_p || (!pwr_down && m_prev && m_cnt < LIM);
            poffc = m_poff_p || (pwr_down && !m_prev);
            free_s = !m_busy || trap_ack;
            iss = 0; te = 0; to = 0; tp = 0; nv = 0;
            if (free_s) begin
                if (c1 || c2 || c3 || c4) begin iss = 1; nv = 'h4D; end
                else if (errc) begin iss = 1; nv = 'h4C; nt = 0; te = 1; end
                else if (poffc && interruptible) begin iss = 1; nv = 'h51; nt = 0; to = 1; end
                else if (ponc) begin iss = 1; nv = 'h50; nt = 0; tp = 1; end
            end
            m_err_p  = errc && !te;
            m_poff_p = poffc && !to;
            m_pon_p  = ponc && !tp;
            if (iss) begin m_busy = 1; m_vec = nv; m_tcc = nt; end
            else if (trap_ack) m_busy = 0;
            m_req   = iss;
            m_retry = hw_err && ok;
            if (proc_fault || c2 || c3) m_pdf = 1;
            else if (pdf_clr) m_pdf = 0;
            if (pwr_down) m_cnt = (m_cnt == LIM) ? m_cnt : m_cnt + 1;
            else m_cnt = 0;
            m_prev = pwr_down;
            if (entry_start) begin m_phase = 1; m_intr = entry_is_intr; end
            else if (m_phase == 1) m_phase = 2;
            else if (m_phase == 2) m_phase = 3;
            else if (m_phase == 3 && exec_done) m_phase = 0;
        end
    end

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running && !done) begin
            chk("trap_req", trap_req, m_req);
            chk("trap_vec", trap_vec, m_vec);
            chk("trap_tcc", trap_tcc, m_tcc);
            chk("retry_grant", retry_grant, m_retry);
            chk("pdf_flag", pdf_flag, m_pdf);
            chk("in_entry", in_entry, m_phase != 0);
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (auto_ack) trap_ack = trap_req;
        end
    endtask

    task automatic exec_op(int op, int cfg, int rg);
        exec_valid = 1; op_class = op[3:0]; mem_cfg = cfg[2:0]; reg_num = rg[3:0];
        cyc(1);
        exec_valid = 0; op_class = 0; mem_cfg = 3'b100; reg_num = 4'd3;
        cyc(3);
    endtask

    task automatic enter(bit intr);
        entry_start = 1; entry_is_intr = intr; cyc(1);
        entry_start = 0; cyc(2);
    endtask

    task automatic leave();
        exec_done = 1; cyc(1); exec_done = 0; cyc(2);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        running = 1;
        cur_req = "R1"; cyc(3); rst = 0; cyc(2);
        // R1 explicit reset-state check
        chk("R1 reset outputs", {trap_req, retry_grant, pdf_flag, in_entry}, 0);

        cur_req = "R2";
        enter(0); cyc(3); leave();

        cur_req = "R3";
        enter(0); exec_op(0, 4, 3); exec_op(1, 4, 3); exec_op(5, 4, 3); leave();
        pdf_clr = 1; cyc(1); pdf_clr = 0;
        enter(1); exec_op(4, 4, 3); exec_op(2, 4, 3); exec_op(8, 4, 3); leave();
        pdf_clr = 1; cyc(1); pdf_clr = 0;

        cur_req = "R4";
        for (int c = 0; c < 8; c++) exec_op(9, c, 3);
        pdf_clr = 1; cyc(1); pdf_clr = 0; cyc(1);

        cur_req = "R5";
        exec_op(6, 4, 3); exec_op(6, 4, 2); exec_op(7, 4, 0); exec_op(8, 4, 0);
        exec_op(7, 4, 5); exec_op(9, 4, 0);
        chk("R5 pdf untouched", pdf_flag, 0);

        cur_req = "R6";
        proc_fault = 1; cyc(1); proc_fault = 0; cyc(3);
        chk("R6 no trap outside entry", trap_vec, 8'h4D);
        enter(0); proc_fault = 1; cyc(1); proc_fault = 0; cyc(3); leave();

        cur_req = "R7";
        enter(0);
        proc_fault = 1; exec_op(9, 0, 0); proc_fault = 0;
        exec_op(9, 0, 0);
        leave();
        exec_op(9, 7, 0);

        cur_req = "R8";
        pdf_clr = 1; proc_fault = 1; cyc(1); proc_fault = 0; cyc(1); pdf_clr = 0; cyc(2);

        cur_req = "R9";
        for (int k = 0; k < 4; k++) begin
            reg_altered = k[0]; retry_inhibit = k[1];
            hw_err = 1; cyc(1); hw_err = 0; cyc(3);
        end
        reg_altered = 0; retry_inhibit = 0;
        cur_req = "R10";
        enter(1); hw_err = 1; cyc(1); hw_err = 0; cyc(3); leave();

        cur_req = "R11";
        interruptible = 0; pwr_down = 1; cyc(6);
        interruptible = 1; cyc(4);

        cur_req = "R12";
        pwr_down = 0; cyc(4);
        pwr_down = 1; cyc(LIM + 10); pwr_down = 0; cyc(5);

        cur_req = "R13";
        auto_ack = 0; trap_ack = 0;
        exec_op(6, 4, 1);
        exec_op(7, 4, 0);
        reg_altered = 1; hw_err = 1; exec_op(6, 4, 1); hw_err = 0; reg_altered = 0;
        pwr_down = 1; cyc(3); pwr_down = 0; cyc(3);
        chk("R13 held vector", trap_vec, 8'h4D);
        for (int k = 0; k < 3; k++) begin
            trap_ack = 1; cyc(1); trap_ack = 0; cyc(3);
        end
        auto_ack = 1; cyc(4);

        finish_run();
    end
endmodule